// File: doc/BRIEF.md
# Dual-Source Output Buffer Arbiter

This block sits between two byte producers, a keyboard source and an auxiliary (pointing device) source, and the single data register the host reads. Each source owns a small byte FIFO; a FIFO that holds at least one byte raises that source's pending flag. From the two flags the block derives the output-buffer-full and auxiliary-buffer-full status bits and repeats them into an output-port byte. It also drives two interrupt levels, one per source, each gated by a mode byte.

When the host reads the data register, the block picks the source that supplies the byte and pops only that FIFO. The keyboard has priority: the auxiliary FIFO is chosen only while it is the only one pending. Status bits follow the FIFO contents in the same cycle. Interrupt levels are registered one cycle behind the pending flags and the mode byte.

Top module: `obuf_arbiter`

## Requirements
- R1: The keyboard flag is set while the keyboard FIFO is non-empty, and the auxiliary flag while the auxiliary FIFO is non-empty. Status bit 0 and port bit 4 are 1 exactly when either flag is set. Both follow the clock edge that changes a FIFO.
- R2: Status bit 5 and port bit 5 are 1 exactly when the auxiliary flag is the only flag set. Every other status and port bit reads 0.
- R3: On a read with a flag set, the byte becomes visible on `host_dout` after the read edge. It comes from the auxiliary FIFO only when the auxiliary flag is the only flag set, and from the keyboard FIFO otherwise. Only the chosen FIFO is popped, and each FIFO returns bytes in the order they were pushed.
- R4: A read with both FIFOs empty leaves `host_dout` at the last byte read, and it leaves every flag and status bit unchanged.
- R5: `kbd_irq` is a registered level. One cycle after the inputs settle, it is 1 exactly when the keyboard flag is set, mode bit 0 is 1 and mode bit 4 is 0.
- R6: `aux_irq` is a registered level. One cycle after the inputs settle, it is 1 exactly when the auxiliary flag is the only flag set and mode bit 1 is 1.
- R7: The mode byte resets to 0x03 and is replaced by `mode_din` on a `mode_we` edge. The interrupt levels reflect a new mode byte one cycle after it is written.
- R8: Each FIFO holds DEPTH bytes (16 by default). A push into a full FIFO is dropped, and the bytes already stored are kept.
- R9: After reset both FIFOs are empty, the status and port bits are 0, both interrupts are low and `host_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| kbd_push | input | 1 | Push `kbd_din` into the keyboard FIFO |
| kbd_din | input | W | Keyboard byte |
| aux_push | input | 1 | Push `aux_din` into the auxiliary FIFO |
| aux_din | input | W | Auxiliary byte |
| host_rd | input | 1 | Host data-register read strobe, one cycle |
| host_dout | output | W | Last byte delivered to the host |
| mode_we | input | 1 | Write strobe for the mode byte |
| mode_din | input | 8 | New mode byte |
| status_bits | output | 8 | Bit 0 buffer full, bit 5 auxiliary buffer full |
| port_bits | output | 8 | Bit 4 buffer full, bit 5 auxiliary buffer full |
| kbd_irq | output | 1 | Keyboard interrupt level |
| aux_irq | output | 1 | Auxiliary interrupt level |

## Verification
The assertions assume `host_rd` is a single-cycle strobe. They also assume a source pushes only bytes it wants kept, so a push into a full FIFO is a legal but lossy event, not an error. The directed tasks pulse each strobe for exactly one cycle and leave idle cycles before sampling, so that the registered interrupt levels have settled. The overflow task deliberately pushes one byte past capacity, and the empty-read task reads only after both FIFOs have been drained.

// File: rtl/obuf_arbiter.sv
module obuf_arbiter #(
  parameter int W     = 8,
  parameter int DEPTH = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         kbd_push,
  input  logic [W-1:0] kbd_din,
  input  logic         aux_push,
  input  logic [W-1:0] aux_din,
  input  logic         host_rd,
  output logic [W-1:0] host_dout,
  input  logic         mode_we,
  input  logic [7:0]   mode_din,
  output logic [7:0]   status_bits,
  output logic [7:0]   port_bits,
  output logic         kbd_irq,
  output logic         aux_irq
);
  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] FULLV = (AW+1)'(DEPTH);

  logic [W-1:0]      mem [2][DEPTH];
  logic [1:0][AW-1:0] wp, rp;
  logic [1:0][AW:0]   cnt;
  logic [1:0][W-1:0]  din;
  logic [1:0]         push, push_ok, pop, pend;
  logic [7:0]         mode_q;
  logic               aux_cur, any_pend;

  assign din  = {aux_din, kbd_din};
  assign push = {aux_push, kbd_push};

  assign pend     = {cnt[1] != '0, cnt[0] != '0};
  assign any_pend = |pend;
  assign aux_cur  = (pend == 2'b10);

  assign pop[1] = host_rd & aux_cur;
  assign pop[0] = host_rd & pend[0];

  always_comb
    for (int s = 0; s < 2; s++)
      push_ok[s] = push[s] & (cnt[s] != FULLV);

  always_ff @(posedge clk)
    for (int s = 0; s < 2; s++)
      if (push_ok[s]) mem[s][wp[s]] <= din[s];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      for (int s = 0; s < 2; s++) begin
        if (push_ok[s]) wp[s] <= wp[s] + 1'b1;
        if (pop[s])     rp[s] <= rp[s] + 1'b1;
        case ({push_ok[s], pop[s]})
          2'b10:   cnt[s] <= cnt[s] + 1'b1;
          2'b01:   cnt[s] <= cnt[s] - 1'b1;
          default: cnt[s] <= cnt[s];
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)               host_dout <= '0;
    else if (pop[1])          host_dout <= mem[1][rp[1]];
    else if (pop[0])          host_dout <= mem[0][rp[0]];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       mode_q <= 8'h03;
    else if (mode_we) mode_q <= mode_din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      kbd_irq <= 1'b0;
      aux_irq <= 1'b0;
    end else begin
      kbd_irq <= pend[0] & mode_q[0] & ~mode_q[4];
      aux_irq <= aux_cur & mode_q[1];
    end
  end

  assign status_bits = {2'b00, aux_cur, 4'b0000, any_pend};
  assign port_bits   = {2'b00, aux_cur, any_pend, 4'b0000};

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt[0] <= FULLV) && (cnt[1] <= FULLV)); // R8
  AST_KBD_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    kbd_irq |-> $past(pend[0] && mode_q[0] && !mode_q[4])); // R5
  AST_AUX_IRQ_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    aux_irq |-> $past(pend == 2'b10 && mode_q[1])); // R6
  AST_EMPTY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && cnt[0] == '0 && cnt[1] == '0) |=> $stable(host_dout)); // R4
  AST_KBD_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && cnt[0] != '0 && !push[1]) |=> $stable(cnt[1])); // R3
  AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(kbd_irq && aux_irq)); // R6
endmodule

// File: tb/obuf_arbiter_tb.sv
module obuf_arbiter_tb;
  logic       clk = 0;
  logic       rst_n = 0;
  logic       kbd_push = 0, aux_push = 0, host_rd = 0, mode_we = 0;
  logic [7:0] kbd_din = 0, aux_din = 0, mode_din = 0;
  logic [7:0] host_dout, status_bits, port_bits;
  logic       kbd_irq, aux_irq;
  int         n_chk = 0, n_bad = 0;
  bit         done = 0;

  always #2 clk = ~clk;

  obuf_arbiter u_dut (
    .clk(clk), .rst_n(rst_n),
    .kbd_push(kbd_push), .kbd_din(kbd_din),
    .aux_push(aux_push), .aux_din(aux_din),
    .host_rd(host_rd), .host_dout(host_dout),
    .mode_we(mode_we), .mode_din(mode_din),
    .status_bits(status_bits), .port_bits(port_bits),
    .kbd_irq(kbd_irq), .aux_irq(aux_irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FIFO-ARB FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_k(logic [7:0] b);
    kbd_din = b; kbd_push = 1; tick(1); kbd_push = 0;
  endtask

  task automatic push_a(logic [7:0] b);
    aux_din = b; aux_push = 1; tick(1); aux_push = 0;
  endtask

  task automatic rd();
    host_rd = 1; tick(1); host_rd = 0;
  endtask

  task automatic set_mode(logic [7:0] m);
    mode_din = m; mode_we = 1; tick(1); mode_we = 0;
  endtask

  task automatic t_reset();
    chk("R9 status", status_bits, 8'h00);
    chk("R9 port", port_bits, 8'h00);
    chk("R9 irqs", {kbd_irq, aux_irq}, 2'b00);
    chk("R9 dout", host_dout, 8'h00);
  endtask

  task automatic t_kbd();
    push_k(8'h11);
    chk("R1 status same cycle", status_bits, 8'h01);
    push_k(8'h22);
    tick(1);
    chk("R1 port", port_bits, 8'h10);
    chk("R5 kbd_irq", kbd_irq, 1);
    chk("R6 aux_irq low", aux_irq, 0);
    rd(); chk("R3 kbd first", host_dout, 8'h11);
    rd(); chk("R3 kbd order", host_dout, 8'h22);
    chk("R1 cleared", status_bits, 8'h00);
    tick(1);
    chk("R5 kbd_irq drops", kbd_irq, 0);
  endtask

  task automatic t_aux();
    push_a(8'h5A);
    tick(1);
    chk("R2 status aux", status_bits, 8'h21);
    chk("R2 port aux", port_bits, 8'h30);
    chk("R6 aux_irq", aux_irq, 1);
    chk("R5 kbd_irq low", kbd_irq, 0);
    rd(); chk("R3 aux read", host_dout, 8'h5A);
    tick(1);
    chk("R6 aux_irq drops", aux_irq, 0);
  endtask

  task automatic t_both();
    push_a(8'hA1);
    push_k(8'hB1);
    tick(1);
    chk("R2 both not aux", status_bits, 8'h01);
    chk("R6 both irqs", {kbd_irq, aux_irq}, 2'b10);
    rd(); chk("R3 kbd priority", host_dout, 8'hB1);
    chk("R3 aux kept", status_bits, 8'h21);
    tick(1);
    chk("R6 aux_irq after kbd drain", aux_irq, 1);
    rd(); chk("R3 aux after", host_dout, 8'hA1);
  endtask

  task automatic t_empty();
    tick(1);
    rd();
    chk("R4 dout held", host_dout, 8'hA1);
    chk("R4 status", status_bits, 8'h00);
    push_k(8'h77); rd();
    chk("R4 state intact", host_dout, 8'h77);
  endtask

  task automatic t_mode();
    set_mode(8'h13);
    push_k(8'h33);
    tick(1);
    chk("R5 disabled kbd irq", kbd_irq, 0);
    chk("R1 status despite disable", status_bits, 8'h01);
    set_mode(8'h03);
    tick(1);
    chk("R7 reenable kbd irq", kbd_irq, 1);
    rd();
    set_mode(8'h01);
    push_a(8'h44);
    tick(1);
    chk("R6 mode1 clear", aux_irq, 0);
    set_mode(8'h03);
    tick(1);
    chk("R7 mode1 set", aux_irq, 1);
    rd();
    chk("R3 aux byte", host_dout, 8'h44);
  endtask

  task automatic t_full();
    for (int i = 0; i < 17; i++) push_k(8'(i + 8'h80));
    for (int i = 0; i < 16; i++) begin
      rd(); chk("R8 fifo order", host_dout, 32'(i + 8'h80));
    end
    chk("R8 extra dropped", status_bits, 8'h00);
    rd(); chk("R8 no 17th", host_dout, 8'h8F);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(1);
    t_reset();
    t_kbd();
    t_aux();
    t_both();
    t_empty();
    t_mode();
    t_full();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FIFO-ARB FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule